// File: doc/BRIEF.md
# APB Address-Space Splitter

This block sits between one APB4 requester and a set of APB4 completers. It looks at every incoming address, picks the single downstream port whose window holds that address, and passes the transfer through to it. The ready, error and read-data signals of that port are returned upstream. The block holds no storage and adds no cycles, so every downstream wait state appears upstream unchanged. An address that falls in a hole between windows does not hang the bus. The block completes that access phase at once, with PSLVERR raised.

The address map is set by two packed parameters, `PORT_BASE` and `PORT_SPAN`, each holding one `ADDR_W`-bit field per port, with port 0 in the lowest field. The default map is:

| Port | Base | Span |
|---|---|---|
| 0 | 0x0000 | 0x100 |
| 1 | 0x0400 | 0x400 |
| 2 | 0x1000 | 0x40 |
| 3 | 0x2000 | 0x1000 |

Elaboration stops with an error if any base is not a multiple of the data-word size in bytes. Writes and reads use separate completion paths, and the upstream PREADY and PSLVERR are the OR of the two paths.

Top module: `apb_splitter`

## Requirements
- R1: While `psel` is high and `paddr` lies in `[base, base+span)` of port i, only `m_psel[i]` is high. When several windows overlap, the lowest index wins. When `psel` is low, or the address hits no window, `m_psel` is all zeros.
- R2: At most one bit of `m_psel` is high in any cycle.
- R3: The following are copied unchanged onto every port's slice, at all times: `m_penable[i]` from `penable`, `m_pwrite[i]` from `pwrite`, `m_pwdata` slice i from `pwdata`, and `m_pstrb` slice i from `pstrb`.
- R4: Slice i of `m_paddr` (bits `i*ADDR_W +: ADDR_W`) holds `(paddr - base_i) mod 2^ADDR_W`, keeping only the low ceil(log2(span_i)) bits. All higher bits are zero.
- R5: During a mapped write, `pready` and `pslverr` equal the selected port's `m_pready` and `m_pslverr`, and `prdata` is zero. Responses from ports that are not selected have no effect.
- R6: During a mapped read, `pready`, `pslverr` and `prdata` equal the selected port's `m_pready`, `m_pslverr` and `m_prdata` slice. Responses from ports that are not selected have no effect.
- R7: While `psel` is low, `pready`, `pslverr` and `prdata` are all zero, whatever the downstream ports drive.
- R8: An access to an address that hits no window drives no `m_psel`. In its access phase (`psel` and `penable` high), `pready` and `pslverr` are both 1 and `prdata` is 0. In its setup phase, `pready` and `pslverr` are 0.
- R9: The first and last byte addresses of each window route to that window. The address one past the end, and the address just below the base, route elsewhere or to the error completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock. Only the bound checker uses it; the datapath is combinational. |
| presetn | input | 1 | Active-low reset, used to qualify the checker. |
| psel | input | 1 | Upstream select |
| penable | input | 1 | Upstream access-phase strobe |
| pwrite | input | 1 | Upstream direction: 1 = write |
| paddr | input | ADDR_W | Upstream byte address |
| pwdata | input | DATA_W | Upstream write data |
| pstrb | input | DATA_W/8 | Upstream byte strobes |
| prdata | output | DATA_W | Read data returned upstream |
| pready | output | 1 | Completion returned upstream |
| pslverr | output | 1 | Error response returned upstream |
| m_psel | output | NPORT | Per-port select |
| m_penable | output | NPORT | Per-port access strobe |
| m_pwrite | output | NPORT | Per-port direction |
| m_paddr | output | NPORT*ADDR_W | Per-port window offset |
| m_pwdata | output | NPORT*DATA_W | Per-port write data |
| m_pstrb | output | NPORT*DATA_W/8 | Per-port byte strobes |
| m_prdata | input | NPORT*DATA_W | Per-port read data |
| m_pready | input | NPORT | Per-port completion |
| m_pslverr | input | NPORT | Per-port error response |

## Verification
In one cycle, the completion of the selected port arrives together with stray ready, error and data values from every port that is not selected. In every cycle, the bench drives random values on all downstream response inputs, and the target's `m_pready` is sometimes low for several cycles, which creates wait states. Its reference model picks the target from the address map alone and predicts each output from that one port. Any leak from another port, or a mix-up between the read and write paths, shows as a mismatch in that same cycle. Window edges and holes are visited for both directions, so decode errors and real completions alternate on successive transfers.

// File: rtl/apbsp_pkg.sv
package apbsp_pkg;

    // Completion pair produced by one fan-in path.
    typedef struct packed {
        logic ack;
        logic err;
    } cpl_t;

    // Mask that keeps the low 'bits' bits of an aw-wide word.
    function automatic logic [63:0] low_mask(input int unsigned bits);
        logic [63:0] m;
        m = '0;
        for (int unsigned b = 0; b < 64; b++) begin
            if (b < bits) m[b] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/apbsp_decode.sv
module apbsp_decode #(
    parameter int                      NPORT     = 4,
    parameter int                      ADDR_W    = 16,
    parameter int                      DATA_W    = 32,
    parameter logic [NPORT*ADDR_W-1:0] PORT_BASE = '0,
    parameter logic [NPORT*ADDR_W-1:0] PORT_SPAN = '0
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    output logic [NPORT-1:0]  rd_sel,
    output logic [NPORT-1:0]  wr_sel,
    output logic              rd_miss,
    output logic              wr_miss
);
    localparam int ALIGN = DATA_W / 8;

    logic [NPORT-1:0] hit;
    logic [NPORT-1:0] pick;

    // Range compare per window, one bit wider to hold base+span.
    for (genvar i = 0; i < NPORT; i++) begin : g_win
        localparam logic [ADDR_W-1:0] BASE = PORT_BASE[i*ADDR_W +: ADDR_W];
        localparam logic [ADDR_W-1:0] SPAN = PORT_SPAN[i*ADDR_W +: ADDR_W];

        if ((BASE % ALIGN) != 0) begin : g_bad_align
            $error("apbsp_decode: window base is not word aligned");
        end

        logic [ADDR_W:0] lo_b;
        logic [ADDR_W:0] hi_b;
        assign lo_b = {1'b0, BASE};
        assign hi_b = {1'b0, BASE} + {1'b0, SPAN};
        assign hit[i] = ({1'b0, paddr} >= lo_b) && ({1'b0, paddr} < hi_b);
    end

    // Lowest-index window wins where windows overlap.
    always_comb begin
        logic found;
        found = 1'b0;
        pick  = '0;
        for (int i = 0; i < NPORT; i++) begin
            if (hit[i] && !found) begin
                pick[i] = 1'b1;
                found   = 1'b1;
            end
        end
    end

    assign rd_sel  = (psel && !pwrite) ? pick : '0;
    assign wr_sel  = (psel &&  pwrite) ? pick : '0;
    assign rd_miss = psel && penable && !pwrite && (pick == '0);
    assign wr_miss = psel && penable &&  pwrite && (pick == '0);

endmodule

// File: rtl/apbsp_fanout.sv
module apbsp_fanout #(
    parameter int                      NPORT     = 4,
    parameter int                      ADDR_W    = 16,
    parameter int                      DATA_W    = 32,
    parameter logic [NPORT*ADDR_W-1:0] PORT_BASE = '0,
    parameter logic [NPORT*ADDR_W-1:0] PORT_SPAN = '0
) (
    input  logic                       penable,
    input  logic                       pwrite,
    input  logic [ADDR_W-1:0]          paddr,
    input  logic [DATA_W-1:0]          pwdata,
    input  logic [DATA_W/8-1:0]        pstrb,
    input  logic [NPORT-1:0]           sel,
    output logic [NPORT-1:0]           m_psel,
    output logic [NPORT-1:0]           m_penable,
    output logic [NPORT-1:0]           m_pwrite,
    output logic [NPORT*ADDR_W-1:0]    m_paddr,
    output logic [NPORT*DATA_W-1:0]    m_pwdata,
    output logic [NPORT*DATA_W/8-1:0]  m_pstrb
);
    import apbsp_pkg::*;

    localparam int STRB_W = DATA_W / 8;

    assign m_psel = sel;

    for (genvar i = 0; i < NPORT; i++) begin : g_port
        localparam logic [ADDR_W-1:0] BASE  = PORT_BASE[i*ADDR_W +: ADDR_W];
        localparam int unsigned       OFF_W = $clog2(PORT_SPAN[i*ADDR_W +: ADDR_W]);
        localparam logic [63:0]       MASK64 = low_mask(OFF_W);
        localparam logic [ADDR_W-1:0] MASK  = MASK64[ADDR_W-1:0];

        logic [ADDR_W-1:0] offset;
        assign offset = paddr - BASE;

        assign m_paddr [i*ADDR_W +: ADDR_W] = offset & MASK;
        assign m_pwdata[i*DATA_W +: DATA_W] = pwdata;
        assign m_pstrb [i*STRB_W +: STRB_W] = pstrb;
        assign m_penable[i]                 = penable;
        assign m_pwrite[i]                  = pwrite;
    end

endmodule

// File: rtl/apbsp_fanin.sv
module apbsp_fanin #(
    parameter int NPORT  = 4,
    parameter int DATA_W = 32
) (
    input  logic [NPORT-1:0]        rd_sel,
    input  logic [NPORT-1:0]        wr_sel,
    input  logic                    rd_miss,
    input  logic                    wr_miss,
    input  logic [NPORT-1:0]        m_pready,
    input  logic [NPORT-1:0]        m_pslverr,
    input  logic [NPORT*DATA_W-1:0] m_prdata,
    output logic                    pready,
    output logic                    pslverr,
    output logic [DATA_W-1:0]       prdata
);
    import apbsp_pkg::*;

    cpl_t wr_c;
    cpl_t rd_c;

    // Write completion path.
    always_comb begin
        wr_c = '0;
        for (int i = 0; i < NPORT; i++) begin
            if (wr_sel[i]) begin
                wr_c.ack = m_pready[i];
                wr_c.err = m_pslverr[i];
            end
        end
        if (wr_miss) begin
            wr_c.ack = 1'b1;
            wr_c.err = wr_miss;
        end
    end

    // Read completion and data path.
    always_comb begin
        rd_c   = '0;
        prdata = '0;
        for (int i = 0; i < NPORT; i++) begin
            if (rd_sel[i]) begin
                rd_c.ack = m_pready[i];
                rd_c.err = m_pslverr[i];
                prdata   = m_prdata[i*DATA_W +: DATA_W];
            end
        end
        if (rd_miss) begin
            rd_c.ack = 1'b1;
            rd_c.err = rd_miss;
        end
    end

    assign pready  = rd_c.ack | wr_c.ack;
    assign pslverr = rd_c.err | wr_c.err;

endmodule

// File: rtl/apb_splitter.sv
module apb_splitter #(
    parameter int                      NPORT     = 4,
    parameter int                      ADDR_W    = 16,
    parameter int                      DATA_W    = 32,
    parameter logic [NPORT*ADDR_W-1:0] PORT_BASE = {16'h2000, 16'h1000, 16'h0400, 16'h0000},
    parameter logic [NPORT*ADDR_W-1:0] PORT_SPAN = {16'h1000, 16'h0040, 16'h0400, 16'h0100}
) (
    input  logic                       pclk,
    input  logic                       presetn,
    input  logic                       psel,
    input  logic                       penable,
    input  logic                       pwrite,
    input  logic [ADDR_W-1:0]          paddr,
    input  logic [DATA_W-1:0]          pwdata,
    input  logic [DATA_W/8-1:0]        pstrb,
    output logic [DATA_W-1:0]          prdata,
    output logic                       pready,
    output logic                       pslverr,
    output logic [NPORT-1:0]           m_psel,
    output logic [NPORT-1:0]           m_penable,
    output logic [NPORT-1:0]           m_pwrite,
    output logic [NPORT*ADDR_W-1:0]    m_paddr,
    output logic [NPORT*DATA_W-1:0]    m_pwdata,
    output logic [NPORT*DATA_W/8-1:0]  m_pstrb,
    input  logic [NPORT*DATA_W-1:0]    m_prdata,
    input  logic [NPORT-1:0]           m_pready,
    input  logic [NPORT-1:0]           m_pslverr
);
    logic [NPORT-1:0] rd_sel;
    logic [NPORT-1:0] wr_sel;
    logic             rd_miss;
    logic             wr_miss;

    apbsp_decode #(
        .NPORT(NPORT), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .PORT_BASE(PORT_BASE), .PORT_SPAN(PORT_SPAN)
    ) u_decode (
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .rd_sel  (rd_sel),
        .wr_sel  (wr_sel),
        .rd_miss (rd_miss),
        .wr_miss (wr_miss)
    );

    apbsp_fanout #(
        .NPORT(NPORT), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .PORT_BASE(PORT_BASE), .PORT_SPAN(PORT_SPAN)
    ) u_fanout (
        .penable   (penable),
        .pwrite    (pwrite),
        .paddr     (paddr),
        .pwdata    (pwdata),
        .pstrb     (pstrb),
        .sel       (rd_sel | wr_sel),
        .m_psel    (m_psel),
        .m_penable (m_penable),
        .m_pwrite  (m_pwrite),
        .m_paddr   (m_paddr),
        .m_pwdata  (m_pwdata),
        .m_pstrb   (m_pstrb)
    );

    apbsp_fanin #(
        .NPORT(NPORT), .DATA_W(DATA_W)
    ) u_fanin (
        .rd_sel    (rd_sel),
        .wr_sel    (wr_sel),
        .rd_miss   (rd_miss),
        .wr_miss   (wr_miss),
        .m_pready  (m_pready),
        .m_pslverr (m_pslverr),
        .m_prdata  (m_prdata),
        .pready    (pready),
        .pslverr   (pslverr),
        .prdata    (prdata)
    );

endmodule

// File: rtl/apbsp_chk.sv
module apbsp_chk #(
    parameter int NPORT  = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input logic                       pclk,
    input logic                       presetn,
    input logic                       psel,
    input logic                       penable,
    input logic                       pwrite,
    input logic [DATA_W-1:0]          pwdata,
    input logic [DATA_W/8-1:0]        pstrb,
    input logic [DATA_W-1:0]          prdata,
    input logic                       pready,
    input logic                       pslverr,
    input logic [NPORT-1:0]           m_psel,
    input logic [NPORT-1:0]           m_penable,
    input logic [NPORT-1:0]           m_pwrite,
    input logic [NPORT*DATA_W-1:0]    m_pwdata,
    input logic [NPORT*DATA_W/8-1:0]  m_pstrb,
    input logic [NPORT*DATA_W-1:0]    m_prdata,
    input logic [NPORT-1:0]           m_pready,
    input logic [NPORT-1:0]           m_pslverr
);
    localparam int STRB_W = DATA_W / 8;

    logic [DATA_W-1:0] sel_rdata;
    always_comb begin
        sel_rdata = '0;
        for (int i = 0; i < NPORT; i++) begin
            if (m_psel[i]) sel_rdata = m_prdata[i*DATA_W +: DATA_W];
        end
    end

    // R2
    one_target_chk: assert property (@(posedge pclk) disable iff (!presetn)
        $onehot0(m_psel));

    // R1
    sel_needs_psel_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (m_psel != '0) |-> psel);

    // R7
    idle_quiet_chk: assert property (@(posedge pclk) disable iff (!presetn)
        !psel |-> (!pready && !pslverr && prdata == '0));

    // R8
    hole_error_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && penable && m_psel == '0) |-> (pready && pslverr && prdata == '0));

    // R5
    wr_follow_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && pwrite && m_psel != '0) |->
            (pready == |(m_psel & m_pready) && pslverr == |(m_psel & m_pslverr) && prdata == '0));

    // R6
    rd_follow_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && !pwrite && m_psel != '0) |->
            (pready == |(m_psel & m_pready) && pslverr == |(m_psel & m_pslverr) && prdata == sel_rdata));

    for (genvar i = 0; i < NPORT; i++) begin : g_bc
        // R3
        broadcast_chk: assert property (@(posedge pclk) disable iff (!presetn)
            m_pwdata[i*DATA_W +: DATA_W] == pwdata && m_pstrb[i*STRB_W +: STRB_W] == pstrb
            && m_penable[i] == penable && m_pwrite[i] == pwrite);
    end

endmodule

bind apb_splitter apbsp_chk #(
    .NPORT(NPORT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/apb_splitter_tb.sv
`timescale 1ns/1ps
module apb_splitter_tb;
    localparam int NP = 4;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int SW = DW / 8;

    logic             clk = 1'b0;
    logic             presetn;
    logic             psel, penable, pwrite;
    logic [AW-1:0]    paddr;
    logic [DW-1:0]    pwdata;
    logic [SW-1:0]    pstrb;
    logic [DW-1:0]    prdata;
    logic             pready, pslverr;
    logic [NP-1:0]    m_psel, m_penable, m_pwrite;
    logic [NP*AW-1:0] m_paddr;
    logic [NP*DW-1:0] m_pwdata;
    logic [NP*SW-1:0] m_pstrb;
    logic [NP*DW-1:0] m_prdata;
    logic [NP-1:0]    m_pready, m_pslverr;

    int    n_chk = 0;
    int    n_bad = 0;
    string ctx   = "reset";

    int unsigned win_base [NP] = '{32'h0000, 32'h0400, 32'h1000, 32'h2000};
    int unsigned win_span [NP] = '{32'h0100, 32'h0400, 32'h0040, 32'h1000};

    always #2.5 clk = ~clk;

    apb_splitter u_dut (
        .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .m_psel(m_psel), .m_penable(m_penable), .m_pwrite(m_pwrite),
        .m_paddr(m_paddr), .m_pwdata(m_pwdata), .m_pstrb(m_pstrb), .m_prdata(m_prdata),
        .m_pready(m_pready), .m_pslverr(m_pslverr)
    );

    function automatic int bits_for(input int unsigned s);
        int b = 0;
        while ((64'd1 << b) < 64'(s)) b++;
        return b;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s (%s) act=%0h exp=%0h", req, what, ctx, act, exp);
        end
    endtask

    // Reference model compared every cycle.
    always @(negedge clk) begin
        int          tgt;
        int unsigned a;
        logic [NP-1:0] esel;
        logic          erdy, eerr;
        logic [DW-1:0] edat;
        string         rq;
        tgt = -1;
        a   = int'(paddr);
        for (int i = 0; i < NP; i++)
            if (tgt < 0 && a >= win_base[i] && a < win_base[i] + win_span[i]) tgt = i;
        esel = (psel && tgt >= 0) ? NP'(1 << tgt) : '0;
        chk("R1", "m_psel", 64'(m_psel), 64'(esel));
        chk("R2", "sel count", 64'($countones(m_psel) <= 1), 64'd1);
        for (int i = 0; i < NP; i++) begin
            int unsigned off;
            chk("R3", "wdata", 64'(m_pwdata[i*DW +: DW]), 64'(pwdata));
            chk("R3", "strb",  64'(m_pstrb[i*SW +: SW]), 64'(pstrb));
            chk("R3", "en/wr", 64'({m_penable[i], m_pwrite[i]}), 64'({penable, pwrite}));
            off = ((a - win_base[i]) & 32'hFFFF) & ((32'd1 << bits_for(win_span[i])) - 1);
            chk("R4", "m_paddr", 64'(m_paddr[i*AW +: AW]), 64'(off));
        end
        if (!psel) begin
            rq = "R7"; erdy = 0; eerr = 0; edat = '0;
        end else if (tgt < 0) begin
            rq = "R8"; erdy = penable; eerr = penable; edat = '0;
        end else begin
            rq   = pwrite ? "R5" : "R6";
            erdy = m_pready[tgt];
            eerr = m_pslverr[tgt];
            edat = pwrite ? '0 : m_prdata[tgt*DW +: DW];
        end
        chk(rq, "pready",  64'(pready),  64'(erdy));
        chk(rq, "pslverr", 64'(pslverr), 64'(eerr));
        chk(rq, "prdata",  64'(prdata),  64'(edat));
    end

    task automatic scramble();
        m_pready  = NP'($urandom);
        m_pslverr = NP'($urandom);
        for (int i = 0; i < NP; i++) m_prdata[i*DW +: DW] = $urandom;
    endtask

    task automatic xfer(input logic [AW-1:0] a, input logic w, input string tag);
        ctx = tag;
        @(posedge clk); #1;
        psel = 1; penable = 0; pwrite = w; paddr = a;
        pwdata = $urandom; pstrb = SW'($urandom);
        scramble();
        for (int k = 0; k < 6; k++) begin
            @(posedge clk); #1;
            penable = 1;
            scramble();
            if (k == 5) m_pready = '1;
            @(negedge clk); #0.5;
            if (pready) break;
        end
        @(posedge clk); #1;
        psel = 0; penable = 0;
        scramble();
    endtask

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog expired (%s)", ctx);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        presetn = 0; psel = 0; penable = 0; pwrite = 0; paddr = '0;
        pwdata = '0; pstrb = '0;
        scramble();
        repeat (4) @(posedge clk);
        #1 presetn = 1;
        // R7: idle with noisy inputs
        ctx = "R7 idle";
        for (int c = 0; c < 12; c++) begin
            @(posedge clk); #1;
            penable = 1'($urandom); pwrite = 1'($urandom); paddr = AW'($urandom);
            pwdata = $urandom; pstrb = SW'($urandom);
            scramble();
        end
        penable = 0;
        // R9: window edges, both directions
        for (int i = 0; i < NP; i++) begin
            for (int w = 0; w < 2; w++) begin
                xfer(AW'(win_base[i]), 1'(w), "R9 first byte");
                xfer(AW'(win_base[i] + win_span[i] - 1), 1'(w), "R9 last byte");
                xfer(AW'(win_base[i] + win_span[i]), 1'(w), "R9 one past end");
                xfer(AW'(win_base[i] - 1), 1'(w), "R9 below base");
                for (int r = 0; r < 3; r++)
                    xfer(AW'(win_base[i] + ($urandom % win_span[i])), 1'(w), "R5/R6 inside");
            end
        end
        // R8: holes
        for (int w = 0; w < 2; w++) begin
            xfer(16'h0100, 1'(w), "R8 hole");
            xfer(16'h03FC, 1'(w), "R8 hole");
            xfer(16'h0900, 1'(w), "R8 hole");
            xfer(16'h1040, 1'(w), "R8 hole");
            xfer(16'h3000, 1'(w), "R8 hole");
            xfer(16'hFFFF, 1'(w), "R8 hole");
        end
        // Mixed random traffic
        for (int n = 0; n < 300; n++)
            xfer(AW'($urandom % 32'h3400), 1'($urandom), "random");
        repeat (3) @(posedge clk);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule